// File: doc/BRIEF.md
# Rate and Burst Float Encoder

This block turns two plain integers into the compact floating form a traffic meter expects. The first is a bucket depth in bytes (32 bits) and the second is a token rate in bits per second (64 bits). Each value is written as (1 + M/256)·2^E, with an 8-bit mantissa and a 5-bit exponent capped at 22. Rates too slow for a zero exponent get a 4-bit time divider instead of a negative exponent. The rate path works on a fixed-point scale where 1,000,000 stands for one unit of mantissa fraction.

A single-cycle `start` captures both inputs. The block then normalises the burst and the rate side by side, one shift per clock. After that it finds the rate mantissa with a restoring subtract loop and publishes every field together with a one-cycle `done`. No floating-point hardware and no divider macro are used. The results stay on the outputs until the next `done`.

Top module: `rate_burst_encoder`

## Requirements
- R1: `burst_exp` is floor(log2(burst)), clamped to 22. A burst of 0 gives exponent 0 and mantissa 0.
- R2: When the burst is below 256, `burst_mant` is 0.
- R3: When the burst is 256 or more, `burst_mant` is the low 8 bits of (burst − 2^floor(log2 burst)) / 2^(burst_exp − 8), where `burst_exp` is the clamped exponent.
- R4: Let W = rate × 64. When W is below 256,000,000, W is doubled until it reaches that value. `rate_exp` is 0 and `rate_div` counts the doublings.
- R5: Otherwise W is halved while W ≥ 512,000,000 and the halving count is at most 22. `rate_exp` is that count clamped to 22, and `rate_div` is 0.
- R6: `rate_mant` is the low 8 bits of (W − 256,000,000) / 1,000,000, using the final W. A rate of 0 gives mantissa 0 and exponent 0.
- R7: `rate_div` saturates at 15. `rate_underflow` is 1 exactly when more than 15 doublings were needed or the rate is 0. A rate of 0 also reports a divider of 15.
- R8: After reset all result outputs, `busy` and `done` are 0. `busy` is 1 from the cycle after an accepted start until the `done` cycle, where it is 0. `done` lasts exactly one cycle. All results change only in a `done` cycle.
- R9: A start that arrives while `busy` is 1 is ignored, and the current job completes with its own inputs.
- R10: `done` appears no more than 112 clock cycles after the edge that accepted the start.
- R11: A start presented in the `done` cycle is accepted and begins a new job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture inputs and begin a conversion when idle |
| burst_in | input | 32 | Bucket depth in bytes |
| rate_in | input | 64 | Token rate in bits per second |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: new results are on the outputs |
| burst_mant | output | 8 | Burst mantissa |
| burst_exp | output | 5 | Burst exponent |
| rate_mant | output | 8 | Rate mantissa |
| rate_exp | output | 5 | Rate exponent |
| rate_div | output | 4 | Rate time divider |
| rate_underflow | output | 1 | Divider saturated, or the rate was zero |

## Verification
The result publication of one job and the acceptance of the next job can fall in the same cycle. The bench provokes this by raising `start` with new operands in the very cycle that `done` is seen. It then judges that `busy` rises on the next cycle, that the first job's results stay in place until the second `done`, and that the second results match the second operands. A related collision is a start during a running job. The bench issues one mid-run with different operands and requires the finished fields to match the first operands.

// File: rtl/rbe_pkg.sv
// Shared types and default constants for the rate and burst float encoder.
// Assumes: the controller uses only the states listed below.
package rbe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NORM = 2'd1,
        ST_DIV  = 2'd2
    } ctl_state_t;

    localparam int unsigned      DEF_EXP_CAP    = 22;
    localparam int unsigned      DEF_RATE_SHIFT = 6;
    localparam longint unsigned  DEF_LOW_MARK   = 64'd256000000;
    localparam longint unsigned  DEF_HIGH_MARK  = 64'd512000000;
    localparam longint unsigned  DEF_SCALE      = 64'd1000000;

endpackage

// File: rtl/rbe_burst_norm.sv
// Iterative burst normaliser: shifts the burst left one place per clock until
// its top bit is set, which locates floor(log2). It then forms the clamped
// exponent and the 8-bit fraction.
// Assumes: load is a one-cycle pulse. Inputs are held internally after load.
module rbe_burst_norm #(
    parameter int unsigned BURST_W = 32,
    parameter int unsigned MAN_W   = 8,
    parameter int unsigned EXP_W   = 5,
    parameter int unsigned EXP_CAP = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BURST_W-1:0] burst_i,
    output logic               busy_o,
    output logic [MAN_W-1:0]   man_o,
    output logic [EXP_W-1:0]   exp_o
);

    localparam int unsigned IDX_W = $clog2(BURST_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(BURST_W - 1);
    localparam logic [IDX_W-1:0] CAP_IDX = IDX_W'(EXP_CAP);
    localparam logic [IDX_W-1:0] FRAC_IDX = IDX_W'(MAN_W);

    logic [BURST_W-1:0] shreg_q;
    logic [MAN_W-1:0]   capped_bits_q;
    logic [IDX_W-1:0]   idx_q;
    logic               zero_q;
    logic               busy_q;
    logic [MAN_W-1:0]   man_next;
    logic [EXP_W-1:0]   exp_next;
    logic               found;

    assign found = shreg_q[BURST_W-1] | zero_q;

    // Exponent and mantissa for the current normalisation position.
    always_comb begin
        if (zero_q) begin
            exp_next = '0;
        end else if (idx_q > CAP_IDX) begin
            exp_next = EXP_W'(EXP_CAP);
        end else begin
            exp_next = EXP_W'(idx_q);
        end
        if (zero_q || (idx_q < FRAC_IDX)) begin
            man_next = '0;
        end else if (idx_q <= CAP_IDX) begin
            man_next = shreg_q[BURST_W-2 -: MAN_W];
        end else begin
            man_next = capped_bits_q;
        end
    end

    // Load, shift one place per clock, and latch the result when normalised.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q       <= '0;
            capped_bits_q <= '0;
            idx_q         <= '0;
            zero_q        <= 1'b0;
            busy_q        <= 1'b0;
            man_o         <= '0;
            exp_o         <= '0;
        end else if (load) begin
            shreg_q       <= burst_i;
            capped_bits_q <= burst_i[EXP_CAP-1 -: MAN_W];
            idx_q         <= TOP_IDX;
            zero_q        <= (burst_i == '0);
            busy_q        <= 1'b1;
        end else if (busy_q) begin
            if (found) begin
                busy_q <= 1'b0;
                man_o  <= man_next;
                exp_o  <= exp_next;
            end else begin
                shreg_q <= shreg_q << 1;
                idx_q   <= idx_q - 1'b1;
            end
        end
    end

    assign busy_o = busy_q;

endmodule

// File: rtl/rbe_rate_norm.sv
// Iterative rate normaliser. It scales the rate by 2^RATE_SHIFT. A slow value
// is doubled until it reaches the low mark, and each doubling counts into a
// saturating divider. A fast value is halved while it is at or above the high
// mark, with the halvings capped. One step per clock.
// Assumes: load is a one-cycle pulse. WORK_W is wide enough for rate << RATE_SHIFT.
module rbe_rate_norm #(
    parameter int unsigned     RATE_W     = 64,
    parameter int unsigned     WORK_W     = 72,
    parameter int unsigned     RATE_SHIFT = 6,
    parameter int unsigned     DIV_W      = 4,
    parameter int unsigned     EXP_W      = 5,
    parameter int unsigned     EXP_CAP    = 22,
    parameter longint unsigned LOW_MARK   = 64'd256000000,
    parameter longint unsigned HIGH_MARK  = 64'd512000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [RATE_W-1:0] rate_i,
    output logic              busy_o,
    output logic              zero_o,
    output logic [WORK_W-1:0] work_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              uf_o
);

    localparam logic [WORK_W-1:0] LOW_V   = WORK_W'(LOW_MARK);
    localparam logic [WORK_W-1:0] HIGH_V  = WORK_W'(HIGH_MARK);
    localparam logic [DIV_W-1:0]  DIV_MAX = '1;
    localparam logic [EXP_W-1:0]  CAP_E   = EXP_W'(EXP_CAP);

    logic [WORK_W-1:0] work_q;
    logic [WORK_W-1:0] load_work;
    logic [EXP_W-1:0]  e_q;
    logic [DIV_W-1:0]  div_q;
    logic              dbl_q;
    logic              zero_q;
    logic              busy_q;
    logic              uf_q;

    assign load_work = {{(WORK_W-RATE_W){1'b0}}, rate_i} << RATE_SHIFT;

    // Load the scaled rate, then take one doubling or halving step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
            e_q    <= '0;
            div_q  <= '0;
            dbl_q  <= 1'b0;
            zero_q <= 1'b0;
            busy_q <= 1'b0;
            uf_q   <= 1'b0;
        end else if (load) begin
            work_q <= load_work;
            e_q    <= '0;
            div_q  <= '0;
            dbl_q  <= (load_work < LOW_V);
            zero_q <= (rate_i == '0);
            busy_q <= 1'b1;
            uf_q   <= 1'b0;
        end else if (busy_q) begin
            if (zero_q) begin
                busy_q <= 1'b0;
                div_q  <= DIV_MAX;
                uf_q   <= 1'b1;
            end else if (dbl_q) begin
                if (work_q < LOW_V) begin
                    work_q <= work_q << 1;
                    if (div_q == DIV_MAX) begin
                        uf_q <= 1'b1;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end else begin
                    busy_q <= 1'b0;
                end
            end else begin
                if ((work_q >= HIGH_V) && (e_q <= CAP_E)) begin
                    work_q <= work_q >> 1;
                    e_q    <= e_q + 1'b1;
                end else begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    // The halving count may pass the cap by one, so clamp it on the way out.
    always_comb begin
        exp_o = (e_q > CAP_E) ? CAP_E : e_q;
    end

    assign busy_o = busy_q;
    assign zero_o = zero_q;
    assign work_o = work_q;
    assign div_o  = div_q;
    assign uf_o   = uf_q;

endmodule

// File: rtl/rbe_restoring_div.sv
// Restoring divider by a fixed constant. It produces one quotient bit per clock
// over DVD_W clocks and exposes the low Q_W quotient bits.
// Assumes: DIVISOR is nonzero and below 2^DVS_W. load is a one-cycle pulse.
module rbe_restoring_div #(
    parameter int unsigned     DVD_W   = 72,
    parameter int unsigned     DVS_W   = 20,
    parameter int unsigned     Q_W     = 8,
    parameter longint unsigned DIVISOR = 64'd1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DVD_W-1:0] dividend_i,
    output logic             busy_o,
    output logic [Q_W-1:0]   quot_o
);

    localparam int unsigned CNT_W = $clog2(DVD_W + 1);
    localparam logic [DVS_W:0]   DVS_V  = (DVS_W + 1)'(DIVISOR);
    localparam logic [CNT_W-1:0] CNT_LD = CNT_W'(DVD_W);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(1);

    logic [DVD_W-1:0] quo_q;
    logic [DVS_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [DVS_W:0]   trial;
    logic             take;

    // Trial subtraction of the divisor from the partial remainder.
    always_comb begin
        trial = {rem_q, quo_q[DVD_W-1]};
        take  = (trial >= DVS_V);
    end

    // Shift in one dividend bit per clock and record one quotient bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            quo_q  <= dividend_i;
            rem_q  <= '0;
            cnt_q  <= CNT_LD;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            rem_q  <= take ? DVS_W'(trial - DVS_V) : trial[DVS_W-1:0];
            quo_q  <= {quo_q[DVD_W-2:0], take};
            cnt_q  <= cnt_q - 1'b1;
            if (cnt_q == CNT_END) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy_o = busy_q;
    assign quot_o = quo_q[Q_W-1:0];

endmodule

// File: rtl/rate_burst_encoder.sv
// Top of the rate and burst float encoder. It accepts a start while idle, runs
// both normalisers side by side, divides the rate offset by the scale and
// publishes all fields together with a one-cycle done.
// Assumes: a start seen while a job runs is dropped. Results hold between done pulses.
module rate_burst_encoder #(
    parameter int unsigned     BURST_W    = 32,
    parameter int unsigned     RATE_W     = 64,
    parameter int unsigned     MAN_W      = 8,
    parameter int unsigned     EXP_W      = 5,
    parameter int unsigned     DIV_W      = 4,
    parameter int unsigned     EXP_CAP    = rbe_pkg::DEF_EXP_CAP,
    parameter int unsigned     RATE_SHIFT = rbe_pkg::DEF_RATE_SHIFT,
    parameter longint unsigned LOW_MARK   = rbe_pkg::DEF_LOW_MARK,
    parameter longint unsigned HIGH_MARK  = rbe_pkg::DEF_HIGH_MARK,
    parameter longint unsigned SCALE      = rbe_pkg::DEF_SCALE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BURST_W-1:0] burst_in,
    input  logic [RATE_W-1:0]  rate_in,
    output logic               busy,
    output logic               done,
    output logic [MAN_W-1:0]   burst_mant,
    output logic [EXP_W-1:0]   burst_exp,
    output logic [MAN_W-1:0]   rate_mant,
    output logic [EXP_W-1:0]   rate_exp,
    output logic [DIV_W-1:0]   rate_div,
    output logic               rate_underflow
);
    import rbe_pkg::*;

    localparam int unsigned WORK_W = RATE_W + RATE_SHIFT + 2;
    localparam int unsigned DVS_W  = $clog2(SCALE + 1);
    localparam logic [WORK_W-1:0] LOW_V = WORK_W'(LOW_MARK);

    ctl_state_t        state_q;
    logic              kick;
    logic              div_kick;
    logic              norm_idle;
    logic              bn_busy;
    logic [MAN_W-1:0]  bn_man;
    logic [EXP_W-1:0]  bn_exp;
    logic              rn_busy;
    logic              rn_zero;
    logic [WORK_W-1:0] rn_work;
    logic [EXP_W-1:0]  rn_exp;
    logic [DIV_W-1:0]  rn_div;
    logic              rn_uf;
    logic [WORK_W-1:0] dividend;
    logic              dv_busy;
    logic [MAN_W-1:0]  dv_quot;

    // Controller decodes: accept, normalisers finished, divider launch.
    always_comb begin
        kick      = start && (state_q == ST_IDLE);
        norm_idle = !bn_busy && !rn_busy;
        div_kick  = (state_q == ST_NORM) && norm_idle && !rn_zero;
        dividend  = rn_work - LOW_V;
    end

    rbe_burst_norm #(
        .BURST_W (BURST_W),
        .MAN_W   (MAN_W),
        .EXP_W   (EXP_W),
        .EXP_CAP (EXP_CAP)
    ) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (kick),
        .burst_i (burst_in),
        .busy_o  (bn_busy),
        .man_o   (bn_man),
        .exp_o   (bn_exp)
    );

    rbe_rate_norm #(
        .RATE_W     (RATE_W),
        .WORK_W     (WORK_W),
        .RATE_SHIFT (RATE_SHIFT),
        .DIV_W      (DIV_W),
        .EXP_W      (EXP_W),
        .EXP_CAP    (EXP_CAP),
        .LOW_MARK   (LOW_MARK),
        .HIGH_MARK  (HIGH_MARK)
    ) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (kick),
        .rate_i (rate_in),
        .busy_o (rn_busy),
        .zero_o (rn_zero),
        .work_o (rn_work),
        .exp_o  (rn_exp),
        .div_o  (rn_div),
        .uf_o   (rn_uf)
    );

    rbe_restoring_div #(
        .DVD_W   (WORK_W),
        .DVS_W   (DVS_W),
        .Q_W     (MAN_W),
        .DIVISOR (SCALE)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (div_kick),
        .dividend_i (dividend),
        .busy_o     (dv_busy),
        .quot_o     (dv_quot)
    );

    // Job sequencing and publication of all result fields at done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_IDLE;
            done           <= 1'b0;
            burst_mant     <= '0;
            burst_exp      <= '0;
            rate_mant      <= '0;
            rate_exp       <= '0;
            rate_div       <= '0;
            rate_underflow <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_NORM;
                    end
                end
                ST_NORM: begin
                    if (norm_idle) begin
                        if (rn_zero) begin
                            state_q        <= ST_IDLE;
                            done           <= 1'b1;
                            burst_mant     <= bn_man;
                            burst_exp      <= bn_exp;
                            rate_mant      <= '0;
                            rate_exp       <= '0;
                            rate_div       <= rn_div;
                            rate_underflow <= rn_uf;
                        end else begin
                            state_q <= ST_DIV;
                        end
                    end
                end
                ST_DIV: begin
                    if (!dv_busy) begin
                        state_q        <= ST_IDLE;
                        done           <= 1'b1;
                        burst_mant     <= bn_man;
                        burst_exp      <= bn_exp;
                        rate_mant      <= dv_quot;
                        rate_exp       <= rn_exp;
                        rate_div       <= rn_div;
                        rate_underflow <= rn_uf;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/rate_burst_encoder_checker.sv
// Protocol and range checker for the rate and burst float encoder, bound to the top.
// Assumes: the same field widths and exponent cap as the top it is bound to.
module rate_burst_encoder_checker #(
    parameter int unsigned MAN_W   = 8,
    parameter int unsigned EXP_W   = 5,
    parameter int unsigned DIV_W   = 4,
    parameter int unsigned EXP_CAP = 22,
    parameter int unsigned MAX_LAT = 112
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [MAN_W-1:0] burst_mant,
    input logic [EXP_W-1:0] burst_exp,
    input logic [MAN_W-1:0] rate_mant,
    input logic [EXP_W-1:0] rate_exp,
    input logic [DIV_W-1:0] rate_div,
    input logic             rate_underflow
);

    localparam logic [DIV_W-1:0] DIV_FULL = '1;
    localparam logic [EXP_W-1:0] CAP_E    = EXP_W'(EXP_CAP);
    localparam logic [EXP_W-1:0] FRAC_E   = EXP_W'(MAN_W);

    logic [15:0] lat_q;

    // Cycles spent busy in the current job.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_q + 1'b1;
        end
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    assert_results_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({burst_mant, burst_exp, rate_mant, rate_exp, rate_div, rate_underflow}));
    assert_burst_exp_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        burst_exp <= CAP_E);
    assert_small_burst_mant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (burst_exp < FRAC_E)) |-> (burst_mant == '0));
    assert_slow_rate_exp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (rate_div != '0)) |-> (rate_exp == '0));
    assert_rate_exp_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rate_exp <= CAP_E);
    assert_underflow_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (rate_div != DIV_FULL)) |-> !rate_underflow);
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (busy || done));
    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q <= 16'(MAX_LAT));
    assert_rearm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> busy);

endmodule

bind rate_burst_encoder rate_burst_encoder_checker #(
    .MAN_W   (MAN_W),
    .EXP_W   (EXP_W),
    .DIV_W   (DIV_W),
    .EXP_CAP (EXP_CAP),
    .MAX_LAT (BURST_W + RATE_W + RATE_SHIFT + 10)
) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .busy           (busy),
    .done           (done),
    .burst_mant     (burst_mant),
    .burst_exp      (burst_exp),
    .rate_mant      (rate_mant),
    .rate_exp       (rate_exp),
    .rate_div       (rate_div),
    .rate_underflow (rate_underflow)
);

// File: tb/rate_burst_encoder_test.sv
// Directed bench for the rate and burst float encoder.
module rate_burst_encoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] burst_in = '0;
    logic [63:0] rate_in = '0;
    logic        busy, done;
    logic [7:0]  burst_mant, rate_mant;
    logic [4:0]  burst_exp, rate_exp;
    logic [3:0]  rate_div;
    logic        rate_underflow;

    int checks = 0;
    int fails = 0;
    longint cycles = 0;

    always #2 clk = ~clk;

    rate_burst_encoder uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .burst_in       (burst_in),
        .rate_in        (rate_in),
        .busy           (busy),
        .done           (done),
        .burst_mant     (burst_mant),
        .burst_exp      (burst_exp),
        .rate_mant      (rate_mant),
        .rate_exp       (rate_exp),
        .rate_div       (rate_div),
        .rate_underflow (rate_underflow)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Reference encoding computed straight from the requirements.
    task automatic model(input logic [31:0] b, input logic [63:0] r,
                         output logic [7:0] bm, output logic [4:0] be,
                         output logic [7:0] rm, output logic [4:0] re,
                         output logic [3:0] rd, output logic uf);
        int fl;
        int ce;
        int dv;
        int ex;
        logic [31:0]  rem;
        logic [127:0] t;
        fl = -1;
        for (int i = 0; i < 32; i++) if (b[i]) fl = i;
        if (fl < 0) begin
            bm = 0; be = 0;
        end else begin
            ce = (fl > 22) ? 22 : fl;
            be = 5'(ce);
            if (b < 256) bm = 0;
            else begin
                rem = b - (32'd1 << fl);
                bm = 8'(rem >> (ce - 8));
            end
        end
        if (r == 0) begin
            rm = 0; re = 0; rd = 4'd15; uf = 1'b1;
        end else begin
            t = {64'd0, r} * 128'd64;
            dv = 0; ex = 0;
            if (t < 128'd256000000) begin
                while (t < 128'd256000000) begin t = t * 2; dv++; end
            end else begin
                while (t >= 128'd512000000 && ex <= 22) begin t = t / 2; ex++; end
                if (ex > 22) ex = 22;
            end
            rm = 8'((t - 128'd256000000) / 128'd1000000);
            re = 5'(ex);
            uf = (dv > 15);
            rd = 4'((dv > 15) ? 15 : dv);
        end
    endtask

    task automatic check_fields(input logic [31:0] b, input logic [63:0] r, input string tag);
        logic [7:0] bm, rm;
        logic [4:0] be, re;
        logic [3:0] rd;
        logic uf;
        model(b, r, bm, be, rm, re, rd, uf);
        chk(burst_exp == be, "R1", {tag, " burst_exp"}, burst_exp, be);
        chk(burst_mant == bm, (b < 256) ? "R2" : "R3", {tag, " burst_mant"}, burst_mant, bm);
        chk(rate_exp == re, "R5", {tag, " rate_exp"}, rate_exp, re);
        chk(rate_mant == rm, "R6", {tag, " rate_mant"}, rate_mant, rm);
        chk(rate_div == rd, "R4", {tag, " rate_div"}, rate_div, rd);
        chk(rate_underflow == uf, "R7", {tag, " rate_underflow"}, rate_underflow, uf);
    endtask

    task automatic kick(input logic [31:0] b, input logic [63:0] r);
        @(negedge clk);
        start = 1'b1; burst_in = b; rate_in = r;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Waits for done, checking busy on the way and the cycle count (R8, R10).
    task automatic wait_done(input string tag);
        int lat;
        bit busy_ok;
        lat = 1;
        busy_ok = 1'b1;
        while (!done && lat < 300) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        chk(busy_ok, "R8", {tag, " busy held"}, busy_ok, 1);
        chk(done && lat <= 112, "R10", {tag, " latency"}, lat, 112);
        chk(!busy, "R8", {tag, " busy low at done"}, busy, 0);
    endtask

    task automatic run(input logic [31:0] b, input logic [63:0] r, input string tag);
        logic [7:0] bm0;
        logic [7:0] rm0;
        kick(b, r);
        wait_done(tag);
        check_fields(b, r, tag);
        bm0 = burst_mant; rm0 = rate_mant;
        @(negedge clk);
        chk(!done, "R8", {tag, " done one cycle"}, done, 0);
        chk(burst_mant == bm0 && rate_mant == rm0, "R8", {tag, " results held"}, rate_mant, rm0);
    endtask

    task automatic t_reset();
        chk(!busy && !done, "R8", "reset busy/done", {busy, done}, 0);
        chk({burst_mant, burst_exp, rate_mant, rate_exp, rate_div, rate_underflow} == '0,
            "R8", "reset results", rate_mant, 0);
    endtask

    task automatic t_burst_small();      // R1, R2
        run(32'd0, 64'd4000000, "burst zero");
        run(32'd1, 64'd4000000, "burst one");
        run(32'd200, 64'd4000000, "burst 200");
        run(32'd255, 64'd4000000, "burst 255");
    endtask

    task automatic t_burst_mid();        // R3
        run(32'd256, 64'd8000000, "burst 256");
        run(32'd300, 64'd8000000, "burst 300");
        run(32'h0001_2345, 64'd1000000000, "burst mid");
        run(32'd8388607, 64'd1000000000, "burst 2^23-1");
    endtask

    task automatic t_burst_large();      // R1 clamp, R3 capped exponent
        run(32'h0080_0000, 64'd5000000, "burst 2^23");
        run(32'hFFFF_FFFF, 64'd5000000, "burst max");
        run(32'h9ABC_DEF1, 64'd5000000, "burst high");
    endtask

    task automatic t_rate_slow();        // R4
        run(32'd1000, 64'd3999999, "rate just below");
        run(32'd1000, 64'd1000, "rate 1000");
        run(32'd1000, 64'd123, "rate 123");
    endtask

    task automatic t_rate_fast();        // R5, R6
        run(32'd4096, 64'd4000000, "rate at low mark");
        run(32'd4096, 64'd8000000, "rate at high mark");
        run(32'd4096, 64'd100000000000, "rate 100G");
        run(32'd4096, 64'hFFFF_FFFF_FFFF_FFFF, "rate max");
        run(32'd4096, 64'd12345678901234, "rate large");
    endtask

    task automatic t_underflow();        // R7
        run(32'd64, 64'd122, "rate 122");
        run(32'd64, 64'd1, "rate one");
        run(32'd64, 64'd0, "rate zero");
    endtask

    task automatic t_ignore();           // R9
        logic [7:0] bm, rm;
        logic [4:0] be, re;
        logic [3:0] rd;
        logic uf;
        kick(32'd1, 64'd1000);
        repeat (5) @(negedge clk);
        start = 1'b1; burst_in = 32'hFFFF_0000; rate_in = 64'd77777777777;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R9", "busy after ignored start", busy, 1);
        wait_done("ignore");
        model(32'd1, 64'd1000, bm, be, rm, re, rd, uf);
        chk(burst_exp == be && rate_div == rd, "R9", "first job fields", {burst_exp, rate_div}, {be, rd});
        check_fields(32'd1, 64'd1000, "ignore");
        @(negedge clk);
        chk(!busy, "R9", "no second job", busy, 0);
    endtask

    task automatic t_back_to_back();     // R11
        logic [7:0] rm0;
        kick(32'd300, 64'd3999999);
        wait_done("b2b first");
        check_fields(32'd300, 64'd3999999, "b2b first");
        rm0 = rate_mant;
        start = 1'b1; burst_in = 32'h0040_0000; rate_in = 64'd100000000000;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R11", "rearm busy", busy, 1);
        chk(rate_mant == rm0, "R8", "first results kept", rate_mant, rm0);
        wait_done("b2b second");
        check_fields(32'h0040_0000, 64'd100000000000, "b2b second");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_burst_small();
        t_burst_mid();
        t_burst_large();
        t_rate_slow();
        t_rate_fast();
        t_underflow();
        t_ignore();
        t_back_to_back();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule